// File: doc/BRIEF.md
# USB Host Transaction Engine

This block is the core of a byte-addressed USB 1.1 host controller. A CPU reaches a 256-byte space over a simple synchronous bus. The low sixteen bytes hold configuration, control and status registers. The rest is a packet buffer that holds payload going out to a device or coming back from it.

Software loads the token PID, the device address, the endpoint number, the buffer start address and the byte count. It then sets one start bit. The engine carries out the whole transaction by itself: token, data stage, handshake.

Packets pass to and from an abstract packet-level PHY as beats. Each beat carries a PID, an optional payload byte, and a last flag. The engine also drives single-ended zero while software holds a two-bit bus-reset field at 01. It reports device attach and bus speed from the synchronised idle line levels.

Top module: `usbh_xact_engine`

## Requirements
- R1: Bus reads and writes at offsets 0x10–0xFF reach the packet buffer. Offsets below 0x10 reach registers. Register layout per endpoint set (base 0x00 or 0x08): +0 control, +1 buffer start, +2 length, +3 status (read-only), +4 token (PID in bits 7:4, endpoint in bits 3:0), +6 device address (bits 6:0), +7 received count (read-only).
- R2: A write with bit 0 = 1 to offset 0x00 or 0x08 while no transaction is active starts a transaction for that set. Bit 6 of the same write selects DATA1 (1) or DATA0 (0). Control bit 0 reads 1 until the result is posted, then reads 0. The other written control bits read back unchanged.
- R3: The token goes out as two beats with the programmed PID. Beat 0 data is {endpoint bit 0, address[6:0]}. Beat 1 data is {5'b0, endpoint[3:1]} with last set.
- R4: When the token PID is not IN (0x9), a data packet follows the token with PID DATA0 (0x3) or DATA1 (0xB). It sends `length` buffer bytes from the start address, the final one marked last. A zero length sends one beat with no-data and last set, and data 0.
- R5: For an IN token, a data packet whose PID equals the selected DATAx is stored from the start address. Storage stops after `length` bytes. The number stored goes to +7. The engine then sends an ACK (0x2) beat with no-data and last set, and status reads 0x03.
- R6: For an IN token, an incoming packet with any other PID, apart from NAK or STALL, ends the transaction with status 0x21. No handshake is sent and the buffer is left unchanged.
- R7: A NAK (0xA) answer ends the transaction with status 0x05. A STALL (0xE) answer ends it with status 0x09. An ACK to an OUT data packet gives 0x03.
- R8: When no response beat arrives within TIMEOUT_CYCLES cycles of entering a wait state, the transaction ends with status 0x11.
- R9: Status bits: bit 0 done, bit 1 ACK, bit 2 NAK, bit 3 STALL, bit 4 timeout, bit 5 PID mismatch. At most one of bits 5:1 is ever set. A start clears the status of the started set to 0x00.
- R10: `bus_se0` is high exactly while bits 4:3 of offset 0x05 hold 01. Writing 00 (or 11) releases it.
- R11: Offset 0x0D reads {6'b0, full_speed, attach}, where attach = dp | dm and full_speed = dp. The values are taken after a two-stage synchroniser.
- R12: While a transaction is active, writes to either endpoint control register are ignored. Writes to offset 0x05 change only bits 4:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | CPU byte address |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data (combinational on address) |
| tx_valid | output | 1 | Outgoing beat valid |
| tx_pid | output | 4 | PID of outgoing packet |
| tx_data | output | 8 | Outgoing payload byte |
| tx_last | output | 1 | Final beat of outgoing packet |
| tx_nodata | output | 1 | Outgoing beat carries no payload byte |
| rx_valid | input | 1 | Incoming beat valid |
| rx_pid | input | 4 | PID of incoming packet |
| rx_data | input | 8 | Incoming payload byte |
| rx_last | input | 1 | Final beat of incoming packet |
| rx_nodata | input | 1 | Incoming beat carries no payload byte |
| line_dp | input | 1 | Idle level of D+ |
| line_dm | input | 1 | Idle level of D- |
| bus_se0 | output | 1 | Force single-ended zero (bus reset) |

## Verification
A sequencer stuck in the wrong state shows first at the packet port: a beat is missing or extra, or carries the wrong PID, within one or two cycles of the start write. A wrong latched byte count or buffer pointer shows up in the data beats of an OUT packet, or in the stored bytes and the count register after an IN packet. A result bit routed wrongly shows up in the status byte in the cycle in which control bit 0 clears. A busy flag that stays set or clears early would let blocked control writes through, or hide the posted result, on the very next read.

// File: rtl/usbh_pkg.sv
package usbh_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int PID_W  = 4;
    localparam int N_EP   = 2;

    localparam logic [ADDR_W-1:0] BUF_BASE = 8'h10;

    localparam logic [PID_W-1:0] PID_OUT   = 4'h1;
    localparam logic [PID_W-1:0] PID_IN    = 4'h9;
    localparam logic [PID_W-1:0] PID_DATA0 = 4'h3;
    localparam logic [PID_W-1:0] PID_DATA1 = 4'hB;
    localparam logic [PID_W-1:0] PID_ACK   = 4'h2;
    localparam logic [PID_W-1:0] PID_NAK   = 4'hA;
    localparam logic [PID_W-1:0] PID_STALL = 4'hE;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_BUF   = 3'd1;
    localparam logic [2:0] OFS_LEN   = 3'd2;
    localparam logic [2:0] OFS_STAT  = 3'd3;
    localparam logic [2:0] OFS_TOKEN = 3'd4;
    localparam logic [2:0] OFS_MISC  = 3'd5;
    localparam logic [2:0] OFS_DEV   = 3'd6;
    localparam logic [2:0] OFS_CNT   = 3'd7;

    localparam int CTRL_TOGGLE_BIT = 6;

    typedef struct packed {
        logic [PID_W-1:0]  pid;
        logic [6:0]        dev;
        logic [3:0]        endp;
        logic [ADDR_W-1:0] start;
        logic [DATA_W-1:0] len;
        logic              toggle;
    } xact_cfg_t;

    typedef struct packed {
        logic mismatch;
        logic timeout;
        logic stall;
        logic nak;
        logic ack;
    } xact_res_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_TOK0, ST_TOK1, ST_DOUT,
        ST_WAIT_HS, ST_WAIT_DIN, ST_RECV, ST_SEND_HS
    } xact_st_t;

    function automatic logic [DATA_W-1:0] status_byte(xact_res_t r);
        return {2'b00, r.mismatch, r.timeout, r.stall, r.nak, r.ack, 1'b1};
    endfunction

    function automatic logic [PID_W-1:0] data_pid(logic t);
        return t ? PID_DATA1 : PID_DATA0;
    endfunction
endpackage

// File: rtl/usbh_linemon.sv
module usbh_linemon (
    input  logic clk,
    input  logic rst,
    input  logic dp,
    input  logic dm,
    output logic attach,
    output logic full_speed
);
    logic [1:0] sync1, sync2;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            sync2 <= '0;
        end else begin
            sync1 <= {dp, dm};
            sync2 <= sync1;
        end
    end

    assign attach     = sync2[1] | sync2[0];
    assign full_speed = sync2[1];
endmodule

// File: rtl/usbh_pktbuf.sv
module usbh_pktbuf
    import usbh_pkg::*;
(
    input  logic              clk,
    input  logic              eng_we,
    input  logic [ADDR_W-1:0] eng_waddr,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic [ADDR_W-1:0] eng_raddr,
    output logic [DATA_W-1:0] eng_rdata,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (eng_we && eng_waddr >= BUF_BASE)
            mem[eng_waddr] <= eng_wdata;
        else if (cpu_we && cpu_addr >= BUF_BASE)
            mem[cpu_addr] <= cpu_wdata;
    end

    assign eng_rdata = mem[eng_raddr];
    assign cpu_rdata = mem[cpu_addr];
endmodule

// File: rtl/usbh_xact_seq.sv
module usbh_xact_seq
    import usbh_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 64
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xact_cfg_t         cfg_in,
    output logic              busy,
    output logic              done,
    output xact_res_t         res,
    output logic [DATA_W-1:0] rx_count,
    output logic              tx_valid,
    output logic [PID_W-1:0]  tx_pid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    output logic              tx_nodata,
    input  logic              rx_valid,
    input  logic [PID_W-1:0]  rx_pid,
    input  logic              rx_last,
    input  logic              rx_nodata,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_waddr,
    output logic [ADDR_W-1:0] buf_raddr,
    input  logic [DATA_W-1:0] buf_rdata
);
    localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYCLES - 1);

    xact_st_t          st;
    xact_cfg_t         cfg;
    logic [DATA_W-1:0] idx;
    logic [DATA_W-1:0] cnt;
    logic [TMO_W-1:0]  tmo;
    logic              is_in, zero_len, pid_ok, room, tmo_hit;

    assign is_in    = (cfg.pid == PID_IN);
    assign zero_len = (cfg.len == '0);
    assign pid_ok   = (rx_pid == data_pid(cfg.toggle));
    assign room     = (cnt < cfg.len);
    assign tmo_hit  = (tmo == TMO_LAST);

    assign busy      = (st != ST_IDLE);
    assign rx_count  = cnt;
    assign buf_raddr = cfg.start + idx;
    assign buf_waddr = cfg.start + cnt;
    assign buf_we    = rx_valid && !rx_nodata && room &&
                       ((st == ST_WAIT_DIN && pid_ok) || st == ST_RECV);

    always_comb begin
        tx_valid  = 1'b0;
        tx_pid    = cfg.pid;
        tx_data   = '0;
        tx_last   = 1'b0;
        tx_nodata = 1'b0;
        case (st)
            ST_TOK0: begin
                tx_valid = 1'b1;
                tx_data  = {cfg.endp[0], cfg.dev};
            end
            ST_TOK1: begin
                tx_valid = 1'b1;
                tx_data  = {5'b0, cfg.endp[3:1]};
                tx_last  = 1'b1;
            end
            ST_DOUT: begin
                tx_valid  = 1'b1;
                tx_pid    = data_pid(cfg.toggle);
                tx_data   = zero_len ? '0 : buf_rdata;
                tx_nodata = zero_len;
                tx_last   = zero_len || (idx == cfg.len - 8'd1);
            end
            ST_SEND_HS: begin
                tx_valid  = 1'b1;
                tx_pid    = PID_ACK;
                tx_last   = 1'b1;
                tx_nodata = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cfg  <= '0;
            idx  <= '0;
            cnt  <= '0;
            tmo  <= '0;
            res  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    cfg <= cfg_in;
                    idx <= '0;
                    cnt <= '0;
                    res <= '0;
                    st  <= ST_TOK0;
                end
                ST_TOK0: st <= ST_TOK1;
                ST_TOK1: begin
                    tmo <= '0;
                    st  <= is_in ? ST_WAIT_DIN : ST_DOUT;
                end
                ST_DOUT: begin
                    if (tx_last) begin
                        tmo <= '0;
                        st  <= ST_WAIT_HS;
                    end else begin
                        idx <= idx + 8'd1;
                    end
                end
                ST_WAIT_HS: begin
                    if (rx_valid) begin
                        case (rx_pid)
                            PID_ACK:   res.ack   <= 1'b1;
                            PID_NAK:   res.nak   <= 1'b1;
                            PID_STALL: res.stall <= 1'b1;
                            default:   res.mismatch <= 1'b1;
                        endcase
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else if (tmo_hit) begin
                        res.timeout <= 1'b1;
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        tmo <= tmo + 1'b1;
                    end
                end
                ST_WAIT_DIN: begin
                    if (rx_valid) begin
                        if (pid_ok) begin
                            if (buf_we) cnt <= cnt + 8'd1;
                            st <= rx_last ? ST_SEND_HS : ST_RECV;
                        end else begin
                            if (rx_pid == PID_NAK)        res.nak   <= 1'b1;
                            else if (rx_pid == PID_STALL) res.stall <= 1'b1;
                            else                          res.mismatch <= 1'b1;
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end
                    end else if (tmo_hit) begin
                        res.timeout <= 1'b1;
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        tmo <= tmo + 1'b1;
                    end
                end
                ST_RECV: if (rx_valid) begin
                    if (buf_we) cnt <= cnt + 8'd1;
                    if (rx_last) st <= ST_SEND_HS;
                end
                ST_SEND_HS: begin
                    res.ack <= 1'b1;
                    st      <= ST_IDLE;
                    done    <= 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usbh_xact_engine.sv
module usbh_xact_engine
    import usbh_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 64
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [PID_W-1:0]  tx_pid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    output logic              tx_nodata,
    input  logic              rx_valid,
    input  logic [PID_W-1:0]  rx_pid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    input  logic              rx_nodata,
    input  logic              line_dp,
    input  logic              line_dm,
    output logic              bus_se0
);
    logic [DATA_W-1:0] ep_ctrl [N_EP];
    logic [DATA_W-1:0] ep_buf  [N_EP];
    logic [DATA_W-1:0] ep_len  [N_EP];
    logic [DATA_W-1:0] ep_stat [N_EP];
    logic [DATA_W-1:0] ep_tok  [N_EP];
    logic [6:0]        ep_dev  [N_EP];
    logic [DATA_W-1:0] ep_cnt  [N_EP];
    logic [DATA_W-1:0] busctl;
    logic              act_ep;

    logic              fsm_busy, fsm_done, busy_any;
    xact_res_t         fsm_res;
    logic [DATA_W-1:0] fsm_cnt;
    xact_cfg_t         cfg_in;
    logic              reg_hit, sel, start_req;
    logic [2:0]        ofs;
    logic              attach, full_speed;
    logic              eng_we;
    logic [ADDR_W-1:0] eng_waddr, eng_raddr;
    logic [DATA_W-1:0] eng_rdata, cpu_rdata;

    assign reg_hit   = (bus_addr < BUF_BASE);
    assign sel       = bus_addr[3];
    assign ofs       = bus_addr[2:0];
    assign busy_any  = fsm_busy | fsm_done;
    assign start_req = bus_wr && reg_hit && (ofs == OFS_CTRL) && bus_wdata[0] && !busy_any;
    assign bus_se0   = (busctl[4:3] == 2'b01);

    always_comb begin
        cfg_in.pid    = ep_tok[sel][7:4];
        cfg_in.endp   = ep_tok[sel][3:0];
        cfg_in.dev    = ep_dev[sel];
        cfg_in.start  = ep_buf[sel];
        cfg_in.len    = ep_len[sel];
        cfg_in.toggle = bus_wdata[CTRL_TOGGLE_BIT];
    end

    usbh_linemon u_line (
        .clk(clk), .rst(rst), .dp(line_dp), .dm(line_dm),
        .attach(attach), .full_speed(full_speed)
    );

    usbh_pktbuf u_buf (
        .clk(clk),
        .eng_we(eng_we), .eng_waddr(eng_waddr), .eng_wdata(rx_data),
        .eng_raddr(eng_raddr), .eng_rdata(eng_rdata),
        .cpu_we(bus_wr && !reg_hit), .cpu_addr(bus_addr),
        .cpu_wdata(bus_wdata), .cpu_rdata(cpu_rdata)
    );

    usbh_xact_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .start(start_req), .cfg_in(cfg_in),
        .busy(fsm_busy), .done(fsm_done), .res(fsm_res), .rx_count(fsm_cnt),
        .tx_valid(tx_valid), .tx_pid(tx_pid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_nodata(tx_nodata),
        .rx_valid(rx_valid), .rx_pid(rx_pid), .rx_last(rx_last), .rx_nodata(rx_nodata),
        .buf_we(eng_we), .buf_waddr(eng_waddr), .buf_raddr(eng_raddr), .buf_rdata(eng_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < N_EP; e++) begin
                ep_ctrl[e] <= '0;
                ep_buf[e]  <= '0;
                ep_len[e]  <= '0;
                ep_stat[e] <= '0;
                ep_tok[e]  <= '0;
                ep_dev[e]  <= '0;
                ep_cnt[e]  <= '0;
            end
            busctl <= '0;
            act_ep <= 1'b0;
        end else begin
            if (bus_wr && reg_hit) begin
                case (ofs)
                    OFS_CTRL:  if (!busy_any) ep_ctrl[sel] <= {bus_wdata[7:1], 1'b0};
                    OFS_BUF:   ep_buf[sel] <= bus_wdata;
                    OFS_LEN:   ep_len[sel] <= bus_wdata;
                    OFS_TOKEN: ep_tok[sel] <= bus_wdata;
                    OFS_DEV:   ep_dev[sel] <= bus_wdata[6:0];
                    OFS_MISC: if (!sel) begin
                        if (busy_any) busctl[4:3] <= bus_wdata[4:3];
                        else          busctl      <= bus_wdata;
                    end
                    default: ;
                endcase
            end
            if (start_req) begin
                act_ep       <= sel;
                ep_stat[sel] <= '0;
                ep_cnt[sel]  <= '0;
            end
            if (fsm_done) begin
                ep_stat[act_ep] <= status_byte(fsm_res);
                ep_cnt[act_ep]  <= fsm_cnt;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!reg_hit) begin
            bus_rdata = cpu_rdata;
        end else begin
            case (ofs)
                OFS_CTRL:  bus_rdata = {ep_ctrl[sel][7:1], busy_any && (act_ep == sel)};
                OFS_BUF:   bus_rdata = ep_buf[sel];
                OFS_LEN:   bus_rdata = ep_len[sel];
                OFS_STAT:  bus_rdata = ep_stat[sel];
                OFS_TOKEN: bus_rdata = ep_tok[sel];
                OFS_MISC:  bus_rdata = sel ? {6'b0, full_speed, attach} : busctl;
                OFS_DEV:   bus_rdata = {1'b0, ep_dev[sel]};
                OFS_CNT:   bus_rdata = ep_cnt[sel];
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/usbh_xact_engine_chk.sv
module usbh_xact_engine_chk
    import usbh_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              wd_start,
    input logic [1:0]        wd_rstfield,
    input logic              bus_se0,
    input logic              tx_valid,
    input logic              tx_last,
    input logic              tx_nodata,
    input logic              busy_any,
    input logic [DATA_W-1:0] busctl,
    input logic [4:0]        stat0_res,
    input logic [4:0]        stat1_res
);
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy_any && bus_wr && bus_addr == 8'h00 && wd_start) |=> busy_any); // R2

    AST_TX_ONLY_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        !busy_any |-> !tx_valid); // R3

    AST_NODATA_IS_LAST: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_nodata) |-> tx_last); // R4

    AST_RESULT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stat0_res) && $onehot0(stat1_res)); // R9

    AST_SE0_FOLLOWS_FIELD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h05 && wd_rstfield == 2'b01) |=> bus_se0); // R10

    AST_BUSCTL_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy_any && bus_wr && bus_addr == 8'h05)
        |=> ({busctl[7:5], busctl[2:0]} == $past({busctl[7:5], busctl[2:0]}))); // R12
endmodule

bind usbh_xact_engine usbh_xact_engine_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .wd_start(bus_wdata[0]), .wd_rstfield(bus_wdata[4:3]),
    .bus_se0(bus_se0), .tx_valid(tx_valid), .tx_last(tx_last), .tx_nodata(tx_nodata),
    .busy_any(busy_any), .busctl(busctl),
    .stat0_res(ep_stat[0][5:1]), .stat1_res(ep_stat[1][5:1])
);

// File: tb/usbh_xact_engine_test.sv
module usbh_xact_engine_test;
    import usbh_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic       bus_wr = 1'b0;
    logic       tx_valid, tx_last, tx_nodata;
    logic [3:0] tx_pid;
    logic [7:0] tx_data;
    logic       rx_valid = 1'b0, rx_last = 1'b0, rx_nodata = 1'b0;
    logic [3:0] rx_pid = '0;
    logic [7:0] rx_data = '0;
    logic       line_dp = 1'b0, line_dm = 1'b0;
    logic       bus_se0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbh_xact_engine #(.TIMEOUT_CYCLES(TMO)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_pid(tx_pid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_nodata(tx_nodata),
        .rx_valid(rx_valid), .rx_pid(rx_pid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_nodata(rx_nodata),
        .line_dp(line_dp), .line_dm(line_dm), .bus_se0(bus_se0)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct packed {
        logic [3:0] pid;
        logic [7:0] data;
        logic       last;
        logic       nodata;
    } beat_t;

    beat_t exp_q[$];
    string tag_q[$];

    task automatic push_beat(input string tag, input logic [3:0] p, input logic [7:0] d,
                             input logic l, input logic nd);
        beat_t b;
        b.pid = p; b.data = d; b.last = l; b.nodata = nd;
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    task automatic push_token(input logic [3:0] p, input logic [6:0] dev, input logic [3:0] ep);
        push_beat("R3 token beat0", p, {ep[0], dev}, 1'b0, 1'b0);
        push_beat("R3 token beat1", p, {5'b0, ep[3:1]}, 1'b1, 1'b0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        beat_t got, want;
        string t;
        if (!rst && tx_valid) begin
            got.pid = tx_pid; got.data = tx_data; got.last = tx_last; got.nodata = tx_nodata;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R6/R12 unexpected tx beat actual=%h expected=none", got);
            end else begin
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                if (got !== want) begin
                    fails++;
                    $display("FAIL %s tx beat actual=%h expected=%h", t, got, want);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rx_beat(input logic [3:0] p, input logic [7:0] d, input logic l, input logic nd);
        @(negedge clk);
        rx_valid = 1'b1; rx_pid = p; rx_data = d; rx_last = l; rx_nodata = nd;
    endtask

    task automatic rx_end;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_nodata = 1'b0;
    endtask

    task automatic wait_idle(input logic [7:0] ctrl_addr);
        logic [7:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(ctrl_addr, v);
            if (!v[0]) return;
        end
        check("R2 done never posted", 8'h01, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(8'h00, v); check("R2 reset ctrl0", v, 8'h00);
        rd(8'h03, v); check("R9 reset status0", v, 8'h00);
        check("R10 reset se0", {7'b0, bus_se0}, 8'h00);

        // R1 buffer and register access
        wr(8'h10, 8'hC3); wr(8'hFF, 8'h3C); wr(8'h01, 8'h77);
        rd(8'h10, v); check("R1 buffer 0x10", v, 8'hC3);
        rd(8'hFF, v); check("R1 buffer 0xFF", v, 8'h3C);
        rd(8'h01, v); check("R1 reg buf start", v, 8'h77);

        // R11 line status
        line_dp = 1'b1; line_dm = 1'b0; repeat (3) @(negedge clk);
        rd(8'h0D, v); check("R11 full-speed attach", v, 8'h03);
        line_dp = 1'b0; line_dm = 1'b1; repeat (3) @(negedge clk);
        rd(8'h0D, v); check("R11 low-speed attach", v, 8'h01);
        line_dp = 1'b0; line_dm = 1'b0; repeat (3) @(negedge clk);
        rd(8'h0D, v); check("R11 detached", v, 8'h00);

        // R4 OUT, DATA1, three bytes, with R12 blocked writes while busy
        wr(8'h20, 8'hA0); wr(8'h21, 8'hA1); wr(8'h22, 8'hA2);
        wr(8'h01, 8'h20); wr(8'h02, 8'd3); wr(8'h04, 8'h15); wr(8'h06, 8'h23);
        push_token(PID_OUT, 7'h23, 4'h5);
        push_beat("R4 out byte0", PID_DATA1, 8'hA0, 1'b0, 1'b0);
        push_beat("R4 out byte1", PID_DATA1, 8'hA1, 1'b0, 1'b0);
        push_beat("R4 out byte2", PID_DATA1, 8'hA2, 1'b1, 1'b0);
        wr(8'h00, 8'h41);
        wr(8'h05, 8'hE7);
        wr(8'h08, 8'h01);
        repeat (4) @(negedge clk);
        rx_beat(PID_ACK, 8'h00, 1'b1, 1'b1); rx_end();
        wait_idle(8'h00);
        rd(8'h03, v); check("R7 out ack status", v, 8'h03);
        rd(8'h00, v); check("R2 self-clear keeps bit6", v, 8'h40);
        rd(8'h05, v); check("R12 busctl locked", v, 8'h00);
        rd(8'h08, v); check("R12 ep1 ctrl ignored", v, 8'h00);

        // R5 IN on set 1, DATA0, longer than length
        wr(8'h40, 8'h5A); wr(8'h41, 8'h5A); wr(8'h42, 8'h5A);
        wr(8'h09, 8'h40); wr(8'h0A, 8'd2); wr(8'h0C, 8'h90); wr(8'h0E, 8'h05);
        push_token(PID_IN, 7'h05, 4'h0);
        push_beat("R5 ack handshake", PID_ACK, 8'h00, 1'b1, 1'b1);
        wr(8'h08, 8'h01);
        rd(8'h08, v); check("R2 busy bit during transaction", v & 8'h01, 8'h01);
        repeat (2) @(negedge clk);
        rx_beat(PID_DATA0, 8'h11, 1'b0, 1'b0);
        rx_beat(PID_DATA0, 8'h22, 1'b0, 1'b0);
        rx_beat(PID_DATA0, 8'h33, 1'b1, 1'b0);
        rx_end();
        wait_idle(8'h08);
        rd(8'h0B, v); check("R5 in status", v, 8'h03);
        rd(8'h0F, v); check("R5 in count", v, 8'd2);
        rd(8'h40, v); check("R5 in byte0", v, 8'h11);
        rd(8'h41, v); check("R5 in byte1", v, 8'h22);
        rd(8'h42, v); check("R5 in stops at length", v, 8'h5A);

        // R6 PID mismatch (expect DATA1, get DATA0)
        push_token(PID_IN, 7'h05, 4'h0);
        wr(8'h08, 8'h41);
        rd(8'h0B, v); check("R9 status cleared on start", v, 8'h00);
        repeat (2) @(negedge clk);
        rx_beat(PID_DATA0, 8'h77, 1'b1, 1'b0); rx_end();
        wait_idle(8'h08);
        rd(8'h0B, v); check("R6 mismatch status", v, 8'h21);
        rd(8'h40, v); check("R6 buffer untouched", v, 8'h11);
        rd(8'h0F, v); check("R6 count zero", v, 8'h00);

        // R7 NAK on IN, set 0
        wr(8'h04, 8'h93); wr(8'h06, 8'h10); wr(8'h01, 8'h50); wr(8'h02, 8'd1);
        push_token(PID_IN, 7'h10, 4'h3);
        wr(8'h00, 8'h01);
        repeat (3) @(negedge clk);
        rx_beat(PID_NAK, 8'h00, 1'b1, 1'b1); rx_end();
        wait_idle(8'h00);
        rd(8'h03, v); check("R7 nak status", v, 8'h05);

        // R4 zero-length OUT, R7 STALL
        wr(8'h04, 8'h10); wr(8'h02, 8'd0);
        push_token(PID_OUT, 7'h10, 4'h0);
        push_beat("R4 zero-length data", PID_DATA0, 8'h00, 1'b1, 1'b1);
        wr(8'h00, 8'h01);
        repeat (5) @(negedge clk);
        rx_beat(PID_STALL, 8'h00, 1'b1, 1'b1); rx_end();
        wait_idle(8'h00);
        rd(8'h03, v); check("R7 stall status", v, 8'h09);

        // R8 timeout
        push_token(PID_IN, 7'h05, 4'h0);
        wr(8'h08, 8'h01);
        wait_idle(8'h08);
        rd(8'h0B, v); check("R8 timeout status", v, 8'h11);

        // R10 bus reset field
        wr(8'h05, 8'h08);
        check("R10 se0 asserted", {7'b0, bus_se0}, 8'h01);
        rd(8'h05, v); check("R10 busctl readback", v, 8'h08);
        wr(8'h05, 8'h18);
        check("R10 field 11 releases", {7'b0, bus_se0}, 8'h00);
        wr(8'h05, 8'h00);
        check("R10 field 00 releases", {7'b0, bus_se0}, 8'h00);

        repeat (4) @(negedge clk);
        check("R3 all expected beats seen", 8'(exp_q.size()), 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule